// File: doc/BRIEF.md
# Auto-Read Fuse Word Controller

This block reads one 32-bit word from an on-chip fuse array without any help from software. Software writes one control register with an enable bit, a read-request bit and a 10-bit word address. The hardware runs the array access itself over a fixed number of cycles. When the access ends, it places the word in a data register and raises a completion flag. Software clears that flag by writing a one to it. An interrupt output follows the completion flag through a mask bit.

A byte offset into the fuse space becomes a word address by dividing it by four, because every access returns four bytes. In the default configuration the array holds 128 bytes, which is 32 words. The lower 96 bytes form a secure region and the upper 32 bytes are open to any requester. The array contents are fixed at elaboration by a seed parameter, so the block needs no file or memory image.

Top module: `fuse_autoread`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The register offsets and fields are fixed.
  - The completion flag is bit 0 at offset 0x18.
  - The interrupt mask is bit 0 at offset 0x1C.
  - The data word is at offset 0x20.
  - The control register is at offset 0x24: bit 0 is enable, bit 1 is read request, and bits [25:16] are the word address.
  - A read from any other offset returns zero.
- R3: A read starts only when one idle-time write to the control register sets both enable and read request. A write with only one of the two bits set starts nothing and leaves the read-request bit at 0. Such a write still stores the enable bit and the address field.
- R4: While an access is in progress, the read-request bit reads 1. It returns to 0 on the cycle the access completes.
- R5: The data word and the completion flag update on the same clock edge. That edge comes exactly `LATENCY` cycles after the edge that accepted the starting write.
- R6: A write to the control register while an access is in progress is ignored. The word returned and the stored address are those of the original request.
- R7: Word i of the array holds `SEED ^ (i * 32'h9E3779B9)`, truncated to 32 bits. A word address of `WORDS` or above returns zero.
- R8: If `bus_secure` is low during the starting write, a request to a word below `SECURE_WORDS` returns zero.
- R9: Writing 1 to bit 0 of offset 0x18 clears the completion flag. Writing 0 to that bit leaves the flag unchanged.
- R10: `irq` is high exactly when both the completion flag and the mask bit are set.
- R11: The data word keeps its value until the next completed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Requester is in the secure domain |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| irq | output | 1 | Masked completion interrupt |

## Verification
The bench builds the block with `LATENCY` = 3, `WORDS` = 32 and `SECURE_WORDS` = 24. With a short latency, every one of the 1024 word addresses can be read in both the secure and the non-secure domain. That sweep covers the in-range words, the secure/non-secure boundary at word 24 and the out-of-range zero region. Each completion is sampled one cycle before and at the exact expected edge. Directed cases then cover the following:
- single-bit control writes
- control writes during an access
- writing zero to the completion flag
- mask combinations
- data retention

// File: rtl/fuse_autoread_pkg.sv
package fuse_autoread_pkg;

   localparam logic [7:0] OFS_STATUS = 8'h18;
   localparam logic [7:0] OFS_MASK   = 8'h1C;
   localparam logic [7:0] OFS_DATA   = 8'h20;
   localparam logic [7:0] OFS_CTRL   = 8'h24;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_REQ_BIT  = 1;
   localparam int CTRL_ADDR_LSB = 16;

   typedef enum logic {SQ_IDLE, SQ_BUSY} seq_state_t;

   function automatic logic [31:0] fuse_word(input logic [31:0] seed, input int unsigned idx);
      logic [31:0] prod;
      prod = 32'(idx) * 32'h9E37_79B9;
      return seed ^ prod;
   endfunction

endpackage

// File: rtl/fuse_rom.sv
module fuse_rom
   import fuse_autoread_pkg::*;
#(
   parameter int          WORDS  = 32,
   parameter int          ADDR_W = 10,
   parameter logic [31:0] SEED   = 32'hC0DE_5EED
) (
   input  logic [ADDR_W-1:0] word_addr,
   output logic [31:0]       word_out
);
   localparam int IDX_W = $clog2(WORDS);

   logic [31:0] table_w [WORDS];

   generate
      for (genvar g = 0; g < WORDS; g++) begin : g_word
         assign table_w[g] = fuse_word(SEED, g);
      end
   endgenerate

   logic in_range;
   assign in_range = (word_addr < ADDR_W'(WORDS));

   always_comb begin
      word_out = '0;
      if (in_range) word_out = table_w[word_addr[IDX_W-1:0]];
   end
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
   import fuse_autoread_pkg::*;
#(
   parameter int LATENCY = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic complete
);
   localparam int CNT_W = $clog2(LATENCY + 1);

   seq_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;

   assign busy     = (state_q == SQ_BUSY);
   assign complete = busy && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: if (start) begin
               state_q <= SQ_BUSY;
               cnt_q   <= CNT_W'(LATENCY - 1);
            end
            SQ_BUSY: begin
               if (cnt_q == '0) state_q <= SQ_IDLE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // R5: an access never lasts longer than LATENCY edges
   a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q <= CNT_W'(LATENCY - 1)));
   // R3: an idle sequencer leaves idle only on a start pulse
   a_r3_start_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !busy);
endmodule

// File: rtl/fuse_csr.sv
module fuse_csr
   import fuse_autoread_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_secure,
   output logic [31:0]       bus_rdata,
   input  logic              busy,
   input  logic              complete,
   input  logic [31:0]       fetched,
   output logic              start,
   output logic [ADDR_W-1:0] word_addr,
   output logic              sec_q,
   output logic              req_q,
   output logic              done_q,
   output logic              mask_q
);
   logic        en_q;
   logic [31:0] data_q;
   logic        wr, ctrl_wr, stat_clr;

   assign wr       = bus_en && bus_we;
   assign ctrl_wr  = wr && (bus_addr == OFS_CTRL) && !busy;
   assign start    = ctrl_wr && bus_wdata[CTRL_EN_BIT] && bus_wdata[CTRL_REQ_BIT];
   assign stat_clr = wr && (bus_addr == OFS_STATUS) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         req_q     <= 1'b0;
         word_addr <= '0;
         sec_q     <= 1'b0;
         data_q    <= '0;
         done_q    <= 1'b0;
         mask_q    <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            en_q      <= bus_wdata[CTRL_EN_BIT];
            req_q     <= start;
            word_addr <= bus_wdata[CTRL_ADDR_LSB +: ADDR_W];
            if (start) sec_q <= bus_secure;
         end
         if (complete) begin
            req_q  <= 1'b0;
            data_q <= fetched;
         end
         if (complete)      done_q <= 1'b1;
         else if (stat_clr) done_q <= 1'b0;
         if (wr && (bus_addr == OFS_MASK)) mask_q <= bus_wdata[0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_STATUS: bus_rdata[0] = done_q;
         OFS_MASK:   bus_rdata[0] = mask_q;
         OFS_DATA:   bus_rdata    = data_q;
         OFS_CTRL: begin
            bus_rdata[CTRL_EN_BIT]              = en_q;
            bus_rdata[CTRL_REQ_BIT]             = req_q;
            bus_rdata[CTRL_ADDR_LSB +: ADDR_W]  = word_addr;
         end
         default: bus_rdata = '0;
      endcase
   end

   // R6: a control write during an access leaves the address untouched
   a_r6_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr && bus_addr == OFS_CTRL) |=> $stable(word_addr));
   // R9: the flag only falls after a write of one to it
   a_r9_w1c_only: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_q) |-> $past(wr && bus_addr == OFS_STATUS && bus_wdata[0]));
   // R11: data changes only on a completion edge
   a_r11_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !complete |=> $stable(data_q));
endmodule

// File: rtl/fuse_autoread.sv
module fuse_autoread
   import fuse_autoread_pkg::*;
#(
   parameter int          WORDS        = 32,
   parameter int          SECURE_WORDS = 24,
   parameter int          LATENCY      = 8,
   parameter logic [31:0] SEED         = 32'hC0DE_5EED
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_en,
   input  logic        bus_we,
   input  logic [7:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   input  logic        bus_secure,
   output logic [31:0] bus_rdata,
   output logic        irq
);
   localparam int ADDR_W = 10;

   generate
      if (LATENCY < 1)              $error("LATENCY must be at least 1");
      if (WORDS < 2 || WORDS > 1024) $error("WORDS must lie in 2..1024");
      if (SECURE_WORDS < 0 || SECURE_WORDS > WORDS) $error("SECURE_WORDS must lie in 0..WORDS");
   endgenerate

   logic              start, busy, complete;
   logic [ADDR_W-1:0] word_addr;
   logic              sec_q, req_q, done_q, mask_q;
   logic [31:0]       rom_word, fetched;

   fuse_seq #(.LATENCY(LATENCY)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .complete(complete)
   );

   fuse_rom #(.WORDS(WORDS), .ADDR_W(ADDR_W), .SEED(SEED)) u_rom (
      .word_addr(word_addr), .word_out(rom_word)
   );

   generate
      if (SECURE_WORDS > 0) begin : g_split
         assign fetched = (sec_q || word_addr >= ADDR_W'(SECURE_WORDS)) ? rom_word : '0;
      end else begin : g_open
         assign fetched = rom_word;
      end
   endgenerate

   fuse_csr #(.ADDR_W(ADDR_W)) u_csr (
      .clk(clk), .rst_n(rst_n),
      .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_rdata(bus_rdata),
      .busy(busy), .complete(complete), .fetched(fetched),
      .start(start), .word_addr(word_addr), .sec_q(sec_q),
      .req_q(req_q), .done_q(done_q), .mask_q(mask_q)
   );

   assign irq = done_q & mask_q;

   // R4: request bit reads set for the whole access
   a_r4_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> req_q);
   // R5: the completion edge of the sequencer sets the flag
   a_r5_done_on_complete: assert property (@(posedge clk) disable iff (!rst_n)
      complete |=> done_q);
   // R10: with the mask clear no interrupt is seen
   a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_q |-> !irq);
endmodule

// File: tb/sim_fuse_autoread.sv
module sim_fuse_autoread;
   localparam int          LAT   = 3;
   localparam int          NW    = 32;
   localparam int          NSEC  = 24;
   localparam logic [31:0] SEED  = 32'hC0DE_5EED;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0, bus_secure = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   fuse_autoread #(.WORDS(NW), .SECURE_WORDS(NSEC), .LATENCY(LAT), .SEED(SEED)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [31:0] expect_word(int a, bit sec);
      if (a >= NW) return 32'h0;
      if (!sec && a < NSEC) return 32'h0;
      return SEED ^ (32'(a) * 32'h9E37_79B9);
   endfunction

   function automatic logic [31:0] ctrl_val(int a, bit en, bit req);
      return {6'b0, 10'(a), 14'b0, req, en};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d, bit sec);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_secure = sec;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; bus_secure = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_en = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R2 unmapped offset
      rd(8'h18, v); chk("R1 status", v, 0);
      rd(8'h1C, v); chk("R1 mask", v, 0);
      rd(8'h20, v); chk("R1 data", v, 0);
      rd(8'h24, v); chk("R1 ctrl", v, 0);
      chk("R1 irq", 32'(irq), 0);
      rd(8'h00, v); chk("R2 unmapped", v, 0);

      // R7 R8 R5 R4: sweep all word addresses in both domains
      for (int s = 0; s < 2; s++) begin
         for (int a = 0; a < 1024; a++) begin
            wr(8'h24, ctrl_val(a, 1, 1), s[0]);
            rd(8'h24, v); chk("R4 req set", v, ctrl_val(a, 1, 1));
            repeat (LAT - 1) @(negedge clk);
            rd(8'h18, v); chk("R5 early", v, 0);
            @(negedge clk);
            rd(8'h18, v); chk("R5 done", v, 1);
            rd(8'h20, v); chk(s ? "R7 word" : "R8 split", v, expect_word(a, s[0]));
            rd(8'h24, v); chk("R4 req clear", v, ctrl_val(a, 1, 0));
            wr(8'h18, 32'h1, 0);
         end
      end
      rd(8'h18, v); chk("R9 cleared", v, 0);

      // R3: single-bit writes start nothing
      rd(8'h20, held);
      wr(8'h24, ctrl_val(5, 0, 1), 1);
      repeat (LAT + 2) @(negedge clk);
      rd(8'h18, v); chk("R3 req only no done", v, 0);
      rd(8'h24, v); chk("R3 req only ctrl", v, ctrl_val(5, 0, 0));
      wr(8'h24, ctrl_val(7, 1, 0), 1);
      repeat (LAT + 2) @(negedge clk);
      rd(8'h18, v); chk("R3 en only no done", v, 0);
      rd(8'h24, v); chk("R3 en only ctrl", v, ctrl_val(7, 1, 0));
      rd(8'h20, v); chk("R11 hold", v, held);

      // R6: write during an access is ignored
      wr(8'h24, ctrl_val(30, 1, 1), 1);
      wr(8'h24, ctrl_val(2, 1, 1), 1);
      repeat (LAT) @(negedge clk);
      rd(8'h20, v); chk("R6 word", v, expect_word(30, 1));
      rd(8'h24, v); chk("R6 ctrl", v, ctrl_val(30, 1, 0));

      // R9: writing zero keeps the flag; R10 interrupt masking
      wr(8'h18, 32'h0, 0);
      rd(8'h18, v); chk("R9 zero write", v, 1);
      chk("R10 unmasked off", 32'(irq), 0);
      wr(8'h1C, 32'h1, 0);
      rd(8'h1C, v); chk("R2 mask read", v, 1);
      chk("R10 irq on", 32'(irq), 1);
      wr(8'h18, 32'h1, 0);
      chk("R10 irq after clear", 32'(irq), 0);

      // R11: data held across idle cycles after clear
      repeat (10) @(negedge clk);
      rd(8'h20, v); chk("R11 idle hold", v, expect_word(30, 1));

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule